// File: doc/BRIEF.md
# Sync Polarity Detector

This block decides which level of a horizontal or vertical sync line is the active pulse level. It brings the raw line into the clock domain, samples it on every counting tick and integrates the samples in a saturating up/down counter. A high sample moves the count up and a low sample moves it down, so the count drifts toward the end of the range that matches the level the line spends most of its time at. Because sync pulses are short compared with the time between them, the dominant level is the inactive one. A line that is mostly high therefore has active-low pulses.

When the count reaches its top value, the block records active-low polarity. When it reaches zero, it records active-high polarity. A valid flag tells the consumer that at least one decision has been made since reset. A fast-mode input halves the counting rate by counting only on alternate clock cycles. The counter cannot wrap, and a decision needs a full sweep of the range to reverse, so short bursts of the minority level leave the result unchanged.

Top module: `sync_polarity_detector`

## Requirements
- R1: After synchronous reset, `pol_valid` is 0 and `active_low` is 0.
- R2: A line that is high for more samples than low, in a periodic pattern, eventually gives `active_low`=1 with `pol_valid`=1.
- R3: A line that is low for more samples than high eventually gives `active_low`=0 with `pol_valid`=1.
- R4: A square wave with equal high and low runs of 4 cycles never reaches either end of the range, so `pol_valid` stays 0.
- R5: The 5-bit counter saturates at 0 and 31 and moves by at most one per tick. After the count has saturated high, a low line causes `active_low` to fall 34 clock edges after it is applied, and not after 33.
- R6: Once set, `pol_valid` stays 1 until reset, whatever the line does.
- R7: With `fast_mode`=1, the counter advances only on alternate cycles. With the line held high from reset, `pol_valid` rises on the 35th edge after reset release, and not on the 34th.
- R8: With `fast_mode`=0 and the line held high from reset, `pol_valid` rises on the 20th edge after reset release, and not on the 19th. This timing follows from three facts: the count resets to 16, both synchronizer stages reset low, and the result register follows the counter by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1: count on alternate cycles only |
| sync_in | input | 1 | Raw asynchronous sync line |
| active_low | output | 1 | 1: sync pulses are active low (line mostly high) |
| pol_valid | output | 1 | A polarity decision has been latched since reset |

## Verification
Periodic patterns with high-dominant, low-dominant and balanced duty cycles are applied from reset in both counting rates. The high- and low-dominant patterns show that the decision follows the majority level. The balanced pattern shows that the counter swings without reaching either end. A line held constant from reset measures the exact decision latency in each rate, which separates the normal rate from the halved rate. A long high run followed by a low run measures the reversal latency, which reveals a counter that wraps instead of saturating. A balanced pattern applied after a decision confirms that the valid flag is sticky.

// File: rtl/sync_pol_pkg.sv
package sync_pol_pkg;
  typedef enum logic {
    POL_ACTIVE_HIGH = 1'b0,
    POL_ACTIVE_LOW  = 1'b1
  } pol_e;
endpackage

// File: rtl/sp_sync_chain.sv
module sp_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= 1'b0;
        else if (i == 0) stage_q[i] <= d_in;
        else stage_q[i] <= stage_q[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/sp_tick_gen.sv
module sp_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic fast_mode,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  // In fast mode only every second cycle counts.
  assign tick = fast_mode ? phase_q : 1'b1;
endmodule

// File: rtl/sp_updown_cnt.sv
module sp_updown_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             up,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_MID;
    end else if (tick) begin
      if (up && cnt_q != CNT_MAX)       cnt_q <= cnt_q + CNT_W'(1);
      else if (!up && cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sp_term_latch.sv
module sp_term_latch
  import sync_pol_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  output logic             pol,
  output logic             valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  pol_e pol_q;
  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q   <= POL_ACTIVE_HIGH;
      valid_q <= 1'b0;
    end else if (cnt == CNT_MAX) begin
      pol_q   <= POL_ACTIVE_LOW;
      valid_q <= 1'b1;
    end else if (cnt == '0) begin
      pol_q   <= POL_ACTIVE_HIGH;
      valid_q <= 1'b1;
    end
  end

  assign pol   = pol_q;
  assign valid = valid_q;
endmodule

// File: rtl/sync_polarity_detector.sv
module sync_polarity_detector #(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_mode,
  input  logic sync_in,
  output logic active_low,
  output logic pol_valid
);
  logic             line_s;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;

  sp_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (sync_in),
    .d_out (line_s)
  );

  sp_tick_gen u_tick (
    .clk       (clk),
    .rst       (rst),
    .fast_mode (fast_mode),
    .tick      (tick)
  );

  sp_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .up   (line_s),
    .cnt  (cnt_q)
  );

  sp_term_latch #(.CNT_W(CNT_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt_q),
    .pol   (active_low),
    .valid (pol_valid)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             fast_mode,
  input logic [CNT_W-1:0] cnt_q,
  input logic             active_low,
  input logic             pol_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |->
      (cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_top_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (pol_valid && active_low));

  assert_bottom_latch_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |=> (pol_valid && !active_low));

  assert_sticky_valid_R6: assert property (@(posedge clk) disable iff (rst)
    pol_valid |=> pol_valid);

  assert_half_rate_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(fast_mode) && fast_mode && cnt_q != $past(cnt_q)) |=> $stable(cnt_q));

  assert_rise_on_terminal_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pol_valid) |-> ($past(cnt_q) == CNT_MAX || $past(cnt_q) == '0));
endmodule

bind sync_polarity_detector sp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fast_mode  (fast_mode),
  .cnt_q      (cnt_q),
  .active_low (active_low),
  .pol_valid  (pol_valid)
);

// File: tb/sync_polarity_detector_tb.sv
module sync_polarity_detector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_mode = 1'b0;
  logic sync_in = 1'b0;
  logic active_low;
  logic pol_valid;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  sync_polarity_detector u_dut (
    .clk        (clk),
    .rst        (rst),
    .fast_mode  (fast_mode),
    .sync_in    (sync_in),
    .active_low (active_low),
    .pol_valid  (pol_valid)
  );

  // Stimulus table: fast, high run, low run, cycles, expected valid, expected polarity
  localparam int NV = 6;
  localparam int    V_FAST [NV] = '{0, 0, 0, 1, 0, 0};
  localparam int    V_HI   [NV] = '{6, 2, 4, 7, 1, 9};
  localparam int    V_LO   [NV] = '{2, 6, 4, 1, 9, 1};
  localparam int    V_CYC  [NV] = '{400, 400, 400, 400, 400, 400};
  localparam bit    V_VAL  [NV] = '{1, 1, 0, 1, 1, 1};
  localparam bit    V_POL  [NV] = '{1, 0, 0, 1, 0, 1};
  localparam string V_REQ  [NV] = '{"R2", "R3", "R4", "R7", "R3", "R2"};

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fast, input logic line);
    rst = 1'b1;
    fast_mode = fast;
    sync_in = line;
    edges(3);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    do_reset(1'b0, 1'b1);
    chk("R1 valid", pol_valid, 1'b0);
    chk("R1 pol", active_low, 1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      do_reset(V_FAST[v] != 0, 1'b1);
      for (int c = 0; c < V_CYC[v]; c++) begin
        sync_in = ((c % (V_HI[v] + V_LO[v])) < V_HI[v]);
        edges(1);
      end
      chk(V_REQ[v], pol_valid, V_VAL[v]);
      chk(V_REQ[v], active_low, V_POL[v]);
    end

    // R8: normal-rate latency with the line held high
    do_reset(1'b0, 1'b1);
    edges(19);
    chk("R8 before", pol_valid, 1'b0);
    edges(1);
    chk("R8 at", pol_valid, 1'b1);
    chk("R8 pol", active_low, 1'b1);

    // R7: halved rate latency
    do_reset(1'b1, 1'b1);
    edges(34);
    chk("R7 before", pol_valid, 1'b0);
    edges(1);
    chk("R7 at", pol_valid, 1'b1);

    // R5: saturation, then reversal latency
    do_reset(1'b0, 1'b1);
    edges(200);
    chk("R5 saturated", active_low, 1'b1);
    sync_in = 1'b0;
    edges(33);
    chk("R5 before", active_low, 1'b1);
    edges(1);
    chk("R5 at", active_low, 1'b0);

    // R6: valid stays set under a balanced line
    for (int c = 0; c < 200; c++) begin
      sync_in = ((c % 8) < 4);
      edges(1);
    end
    chk("R6 valid", pol_valid, 1'b1);
    chk("R6 pol", active_low, 1'b0);

    // R1: reset clears the decision again
    do_reset(1'b0, 1'b0);
    chk("R1 again", pol_valid, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule